// File: doc/BRIEF.md
# Parity-Checked Multi-Lane Pixel Deserializer

This block turns a serial pixel stream into a parallel pixel bus. A recovered line-rate bit clock drives it. A frame-start marker is high on the first bit slot of each frame. Every frame is 30 bits long and arrives over one, two or three data lanes. A configuration input sets the number of lanes, and the block captures that setting at each frame start. The 30 bits gather in one shift register. When a frame is complete, its even parity is checked over the 27 payload bits.

A frame with good parity is decoded into 8 bits each of red, green and blue plus vertical sync, horizontal sync and data enable. The decoded word is placed on a 27-bit output bus and a regenerated pixel strobe rises. A frame with bad parity is thrown away. The previous word stays on the bus and the error output goes high for that pixel period. A swap input flips the bus between two layouts. The block drives a fixed idle pattern in two cases. The first lasts from reset until the first good frame. The second starts when no frame-start marker has arrived within a programmable number of clock cycles.

Top module: `pixel_deser`

## Requirements
- R1: The lane count code is sampled at the frame-start cycle: 3 means three lanes, 2 means two lanes, and 0 or 1 means one lane. With N lanes, lane k carries frame bit k+N*c in bit slot c, so a frame takes 30, 15 or 10 slots.
- R2: Frame bits 7:0 are red, 15:8 green, 23:16 blue, 24 vertical sync, 25 horizontal sync and 26 data enable. Bit 27 is even parity, so bits 0 to 27 together hold an even number of ones. Bits 28 and 29 are framing bits and are not checked.
- R3: A frame with good parity updates the bus two clock edges after its last slot is sampled, and the error output reads low.
- R4: After a frame with bad parity, the bus keeps the last good word and the error output is high until the next frame completes.
- R5: With swap low, the bus is {R[7:0], G[7:0], B[7:0], VS, HS, DE}, with bit 26 on the left. With swap high, it is {B[0:7], G[0:7], R[0:7], VS, HS, DE}, each colour bit-reversed. Swap acts on the held word at once.
- R6: Idle state: the bus is all ones except DE (bit 0), which is 0, and the strobe and error outputs are low. Idle holds from reset until the first good frame. A bad frame received while idle leaves the block idle.
- R7: If no frame-start marker is seen for wd_limit cycles, the block returns to idle. The next good frame makes it active again.
- R8: While active, the pixel strobe rises with each completed frame and stays high for 15, 7 or 5 cycles for one, two or three lanes.
- R9: A frame-start marker in the middle of a frame drops the partial frame and starts a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered line-rate bit clock |
| rst | input | 1 | Synchronous active-high reset |
| lane_cnt | input | 2 | Lane count code, sampled at frame start |
| sof | input | 1 | Frame-start marker, high in bit slot 0 |
| lane_in | input | 3 | Serial data lanes; lane 0 is always used |
| swap | input | 1 | Selects the reversed bus layout |
| wd_limit | input | WD_W | Cycles without a frame start before going idle |
| bus_o | output | 27 | Parallel pixel and control bus |
| err_o | output | 1 | Parity error indication for the current pixel period |
| pclk_o | output | 1 | Regenerated pixel strobe |

## Verification
The hardest case to reach is the interaction of idle state with the parity path. A bad frame must be dropped both before any good word exists and right after a good one. The watchdog must then pull the bus back to idle between frames. The stimulus reaches these cases in steps. It sends a bad frame straight after reset and checks that the idle pattern stays. It then sends runs of frames in each lane mode with single and back-to-back bad frames. Finally it lowers wd_limit and holds the frame-start marker off, then recovers with a fresh good frame. A truncated frame followed by a new marker covers restart mid-frame.

// File: rtl/pd_pkg.sv
package pd_pkg;

    localparam int FRAME_W = 30;
    localparam int PAY_W   = 27;
    localparam int COLOR_W = 8;
    localparam int LANES   = 3;
    localparam int PAR_POS = PAY_W;
    localparam int SLOT_W  = $clog2(FRAME_W + 1);

    typedef logic [FRAME_W-1:0] frame_t;
    typedef logic [PAY_W-1:0]   bus_t;

    typedef struct packed {
        logic [COLOR_W-1:0] red;
        logic [COLOR_W-1:0] grn;
        logic [COLOR_W-1:0] blu;
        logic               vs;
        logic               hs;
        logic               de;
    } pix_word_t;

    localparam bus_t IDLE_BUS = {{(PAY_W-1){1'b1}}, 1'b0};

    function automatic logic [1:0] norm_mode(input logic [1:0] code);
        return (code == 2'd0) ? 2'd1 : code;
    endfunction

    function automatic logic [SLOT_W-1:0] beats_of(input logic [1:0] mode);
        case (mode)
            2'd3:    return SLOT_W'(FRAME_W / 3);
            2'd2:    return SLOT_W'(FRAME_W / 2);
            default: return SLOT_W'(FRAME_W);
        endcase
    endfunction

    function automatic logic [SLOT_W-1:0] half_of(input logic [1:0] mode);
        return beats_of(mode) >> 1;
    endfunction

    function automatic frame_t shift_in(input frame_t sr, input logic [LANES-1:0] ln,
                                        input logic [1:0] mode);
        case (mode)
            2'd3:    return {ln[2], ln[1], ln[0], sr[FRAME_W-1:3]};
            2'd2:    return {ln[1], ln[0], sr[FRAME_W-1:2]};
            default: return {ln[0], sr[FRAME_W-1:1]};
        endcase
    endfunction

    function automatic logic parity_good(input frame_t f);
        return ~(^f[PAR_POS:0]);
    endfunction

    function automatic pix_word_t decode(input frame_t f);
        pix_word_t w;
        w.red = f[COLOR_W-1:0];
        w.grn = f[2*COLOR_W-1:COLOR_W];
        w.blu = f[3*COLOR_W-1:2*COLOR_W];
        w.vs  = f[3*COLOR_W];
        w.hs  = f[3*COLOR_W+1];
        w.de  = f[3*COLOR_W+2];
        return w;
    endfunction

    function automatic logic [COLOR_W-1:0] rev_color(input logic [COLOR_W-1:0] c);
        logic [COLOR_W-1:0] r;
        for (int i = 0; i < COLOR_W; i++) r[i] = c[COLOR_W-1-i];
        return r;
    endfunction

    function automatic bus_t bus_map(input pix_word_t w, input logic swp);
        if (swp)
            return {rev_color(w.blu), rev_color(w.grn), rev_color(w.red), w.vs, w.hs, w.de};
        return {w.red, w.grn, w.blu, w.vs, w.hs, w.de};
    endfunction

endpackage

// File: rtl/pd_lane_shift.sv
module pd_lane_shift
    import pd_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          lane_cnt,
    input  logic                sof,
    input  logic [LANES-1:0]    lane_in,
    output frame_t              frame_q,
    output logic                frame_vld,
    output logic [1:0]          mode_q
);

    logic [SLOT_W-1:0] slot_q;
    logic              busy_q;
    logic [1:0]        mode_now;

    assign mode_now = norm_mode(lane_cnt);

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q   <= '0;
            frame_vld <= 1'b0;
            slot_q    <= '0;
            busy_q    <= 1'b0;
            mode_q    <= 2'd1;
        end else begin
            frame_vld <= 1'b0;
            if (sof) begin
                mode_q  <= mode_now;
                frame_q <= shift_in(frame_q, lane_in, mode_now);
                slot_q  <= SLOT_W'(1);
                busy_q  <= 1'b1;
            end else if (busy_q) begin
                frame_q <= shift_in(frame_q, lane_in, mode_q);
                if (slot_q == beats_of(mode_q) - SLOT_W'(1)) begin
                    frame_vld <= 1'b1;
                    busy_q    <= 1'b0;
                    slot_q    <= '0;
                end else begin
                    slot_q <= slot_q + SLOT_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/pd_link_watch.sv
module pd_link_watch #(
    parameter int WD_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sof,
    input  logic [WD_W-1:0] wd_limit,
    output logic            lost
);

    localparam logic [WD_W-1:0] CNT_MAX = '1;

    logic [WD_W-1:0] quiet_q;

    always_ff @(posedge clk) begin
        if (rst || sof)
            quiet_q <= '0;
        else if (quiet_q != CNT_MAX)
            quiet_q <= quiet_q + WD_W'(1);
    end

    assign lost = (quiet_q >= wd_limit);

endmodule

// File: rtl/pd_word_stage.sv
module pd_word_stage
    import pd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  frame_t     frame_q,
    input  logic       frame_vld,
    input  logic [1:0] mode_q,
    input  logic       lost,
    output pix_word_t  word_q,
    output logic       err_q,
    output logic       strobe_q,
    output logic       live_q
);

    logic [SLOT_W-1:0] hi_left_q;
    logic              good;

    assign good = parity_good(frame_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q    <= '0;
            err_q     <= 1'b0;
            strobe_q  <= 1'b0;
            live_q    <= 1'b0;
            hi_left_q <= '0;
        end else if (frame_vld) begin
            strobe_q  <= 1'b1;
            hi_left_q <= half_of(mode_q) - SLOT_W'(1);
            err_q     <= ~good;
            if (good) begin
                word_q <= decode(frame_q);
                live_q <= 1'b1;
            end
        end else if (lost) begin
            live_q   <= 1'b0;
            err_q    <= 1'b0;
            strobe_q <= 1'b0;
        end else if (strobe_q) begin
            if (hi_left_q == '0)
                strobe_q <= 1'b0;
            else
                hi_left_q <= hi_left_q - SLOT_W'(1);
        end
    end

endmodule

// File: rtl/pixel_deser.sv
module pixel_deser
    import pd_pkg::*;
#(
    parameter int WD_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       lane_cnt,
    input  logic             sof,
    input  logic [2:0]       lane_in,
    input  logic             swap,
    input  logic [WD_W-1:0]  wd_limit,
    output logic [26:0]      bus_o,
    output logic             err_o,
    output logic             pclk_o
);

    frame_t     frame_q;
    logic       frame_vld;
    logic [1:0] mode_q;
    logic       lost;
    pix_word_t  word_q;
    logic       err_q;
    logic       strobe_q;
    logic       live_q;

    pd_lane_shift u_shift (
        .clk       (clk),
        .rst       (rst),
        .lane_cnt  (lane_cnt),
        .sof       (sof),
        .lane_in   (lane_in),
        .frame_q   (frame_q),
        .frame_vld (frame_vld),
        .mode_q    (mode_q)
    );

    pd_link_watch #(.WD_W(WD_W)) u_watch (
        .clk      (clk),
        .rst      (rst),
        .sof      (sof),
        .wd_limit (wd_limit),
        .lost     (lost)
    );

    pd_word_stage u_stage (
        .clk       (clk),
        .rst       (rst),
        .frame_q   (frame_q),
        .frame_vld (frame_vld),
        .mode_q    (mode_q),
        .lost      (lost),
        .word_q    (word_q),
        .err_q     (err_q),
        .strobe_q  (strobe_q),
        .live_q    (live_q)
    );

    assign bus_o  = live_q ? bus_map(word_q, swap) : IDLE_BUS;
    assign err_o  = live_q & err_q;
    assign pclk_o = live_q & strobe_q;

endmodule

// File: rtl/pd_chk.sv
module pd_chk
    import pd_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        swap,
    input logic [26:0] bus_o,
    input logic        err_o,
    input logic        pclk_o,
    input logic        frame_vld,
    input logic        lost
);

    // R1
    vld_single_chk: assert property (@(posedge clk) disable iff (rst)
        frame_vld |=> !frame_vld);

    // R4
    hold_on_err_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(err_o) && $stable(swap)) |-> $stable(bus_o));

    // R6
    idle_after_rst_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (bus_o == IDLE_BUS && !pclk_o && !err_o));

    // R7
    idle_on_loss_chk: assert property (@(posedge clk) disable iff (rst)
        (lost && !frame_vld) |=> (bus_o == IDLE_BUS && !pclk_o && !err_o));

    // R8
    strobe_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pclk_o) |-> $past(frame_vld));

endmodule

bind pixel_deser pd_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .swap      (swap),
    .bus_o     (bus_o),
    .err_o     (err_o),
    .pclk_o    (pclk_o),
    .frame_vld (frame_vld),
    .lost      (lost)
);

// File: tb/tb_pixel_deser.sv
module tb_pixel_deser;

    localparam int CLK_PERIOD = 10;
    localparam int WD_W = 16;
    localparam logic [26:0] IDLE = {26'h3FFFFFF, 1'b0};

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [1:0]      lane_cnt = 2'd1;
    logic            sof = 1'b0;
    logic [2:0]      lane_in = 3'b000;
    logic            swap = 1'b0;
    logic [WD_W-1:0] wd_limit = 16'd1000;
    logic [26:0]     bus_o;
    logic            err_o;
    logic            pclk_o;

    pixel_deser #(.WD_W(WD_W)) dut (
        .clk(clk), .rst(rst), .lane_cnt(lane_cnt), .sof(sof), .lane_in(lane_in),
        .swap(swap), .wd_limit(wd_limit), .bus_o(bus_o), .err_o(err_o), .pclk_o(pclk_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic [26:0] bus;
        logic        err;
        string       req;
    } exp_t;

    exp_t        exp_q[$];
    int          n_run = 0;
    int          n_fail = 0;
    bit          model_live = 0;
    logic [26:0] last_pay = '0;
    bit          done = 0;
    logic        pclk_prev = 1'b0;

    function automatic logic [7:0] rv(input logic [7:0] c);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = c[7-i];
        return r;
    endfunction

    function automatic logic [26:0] enc(input logic [26:0] p, input logic s);
        if (s) return {rv(p[23:16]), rv(p[15:8]), rv(p[7:0]), p[24], p[25], p[26]};
        return {p[7:0], p[15:8], p[23:16], p[24], p[25], p[26]};
    endfunction

    task automatic check(input bit ok, input string req, input logic [26:0] act,
                         input logic [26:0] expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic drive_beats(input logic [29:0] f, input int nb);
        int n;
        n = (lane_cnt == 2'd3) ? 3 : (lane_cnt == 2'd2) ? 2 : 1;
        for (int c = 0; c < nb; c++) begin
            @(negedge clk);
            sof = (c == 0);
            for (int k = 0; k < 3; k++) lane_in[k] = (k < n) ? f[c*n+k] : 1'b0;
        end
    endtask

    task automatic send_frame(input logic [26:0] p, input bit bad, input string req);
        logic [29:0] f;
        int nb;
        exp_t e;
        nb = (lane_cnt == 2'd3) ? 10 : (lane_cnt == 2'd2) ? 15 : 30;
        f = {1'b0, 1'b1, (^p) ^ bad, p};
        if (!bad) begin
            e.bus = enc(p, swap); e.err = 1'b0; e.req = req;
            exp_q.push_back(e);
            model_live = 1; last_pay = p;
        end else if (model_live) begin
            e.bus = enc(last_pay, swap); e.err = 1'b1; e.req = req;
            exp_q.push_back(e);
        end
        drive_beats(f, nb);
    endtask

    task automatic gap(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sof = 1'b0;
            lane_in = 3'b000;
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && pclk_o && !pclk_prev) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 unexpected strobe", bus_o, '0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(bus_o == e.bus, e.req, bus_o, e.bus);
                check(err_o == e.err, e.req, {26'd0, err_o}, {26'd0, e.err});
            end
        end
        pclk_prev = pclk_o;
    end

    task automatic finish_run;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            finish_run();
        end
    end

    initial begin
        int hi;
        gap(3);
        rst = 1'b0;
        gap(1);
        // R6 reset state
        check(bus_o == IDLE, "R6 reset bus", bus_o, IDLE);
        check(!pclk_o, "R6 reset strobe", {26'd0, pclk_o}, '0);
        check(!err_o, "R6 reset err", {26'd0, err_o}, '0);

        // R6 bad frame while idle keeps idle
        lane_cnt = 2'd3;
        send_frame(27'h1234567, 1'b1, "R6");
        gap(6);
        check(bus_o == IDLE, "R6 bad frame idle bus", bus_o, IDLE);
        check(!err_o, "R6 bad frame idle err", {26'd0, err_o}, '0);

        // R1 R2 R3 one lane (code 0 means one lane)
        lane_cnt = 2'd0;
        send_frame(27'h5A5A5A5, 1'b0, "R1 one lane");
        lane_cnt = 2'd1;
        send_frame(27'h00000FF, 1'b0, "R2 red field");
        send_frame(27'h4000000, 1'b0, "R2 de bit");
        gap(4);

        // R4 two lanes with a bad frame in between
        lane_cnt = 2'd2;
        send_frame(27'h2ABCDEF, 1'b0, "R3 two lanes");
        send_frame(27'h0F0F0F0, 1'b1, "R4 held after bad");
        send_frame(27'h1000001, 1'b0, "R3 recover");
        gap(4);

        // R4 three lanes, consecutive bad frames
        lane_cnt = 2'd3;
        send_frame(27'h3C3C3C3, 1'b0, "R1 three lanes");
        send_frame(27'h7FFFFFF, 1'b1, "R4 first bad");
        send_frame(27'h0000001, 1'b1, "R4 second bad");
        send_frame(27'h2000000, 1'b0, "R2 hs bit");
        gap(14);

        // R5 swapped layout
        swap = 1'b1;
        gap(1);
        check(bus_o == enc(27'h2000000, 1'b1), "R5 swap immediate", bus_o, enc(27'h2000000, 1'b1));
        send_frame(27'h1F80C01, 1'b0, "R5 swapped frame");
        gap(14);
        swap = 1'b0;
        gap(1);
        check(bus_o == enc(27'h1F80C01, 1'b0), "R5 unswap immediate", bus_o, enc(27'h1F80C01, 1'b0));

        // R9 partial frame dropped by restart
        lane_cnt = 2'd2;
        drive_beats({1'b0, 1'b1, 1'b0, 27'h7777777}, 6);
        send_frame(27'h0123456, 1'b0, "R9 restart");
        gap(2);

        // R8 strobe high time, two lanes
        while (!(pclk_o && !pclk_prev)) @(negedge clk);
        hi = 0;
        while (pclk_o) begin hi++; @(negedge clk); end
        check(hi == 7, "R8 two-lane strobe width", 27'(hi), 27'd7);
        gap(10);

        // R8 three lanes
        lane_cnt = 2'd3;
        send_frame(27'h0AAAAAA, 1'b0, "R8 frame");
        gap(1);
        while (!(pclk_o && !pclk_prev)) @(negedge clk);
        hi = 0;
        while (pclk_o) begin hi++; @(negedge clk); end
        check(hi == 5, "R8 three-lane strobe width", 27'(hi), 27'd5);

        // R7 watchdog returns to idle
        wd_limit = 16'd50;
        gap(70);
        model_live = 0;
        check(bus_o == IDLE, "R7 loss idle bus", bus_o, IDLE);
        check(!pclk_o, "R7 loss strobe", {26'd0, pclk_o}, '0);
        send_frame(27'h1515151, 1'b0, "R7 recovery frame");
        gap(5);
        check(bus_o == enc(27'h1515151, 1'b0), "R7 active again", bus_o, enc(27'h1515151, 1'b0));

        gap(20);
        check(exp_q.size() == 0, "R3 all frames seen", 27'(exp_q.size()), '0);
        done = 1;
        finish_run();
    end

endmodule